// File: doc/BRIEF.md
# QoS-Weighted Request Arbiter

This block sits in front of one shared target port and chooses which of several initiators may present an address-channel request to it. Each initiator offers a valid flag, a 4-bit priority value and an address payload. The priority value ranges from 0, the lowest, to 15, the highest. In every cycle where no grant is held, the arbiter compares the priority values of the initiators whose valid is high and grants one that carries the largest value. Initiators whose valid is low take no part in the comparison.

A grant whose handshake does not complete in the same cycle is locked. It stays on the same initiator until the target raises ready while that initiator is still valid. The next arbitration then starts from the requests present at that moment, so a high-priority request that arrives late is served before lower-priority requests that have waited longer. When the highest value is shared by several initiators, a round-robin pointer decides between them. The pointer moves to the index just after the last initiator that completed a handshake. The selected payload and priority are steered to the target side, and ready is returned only to the granted initiator.

This arbiter gives high-priority initiators a bounded wait. It gives low-priority initiators no guaranteed share of the port.

Top module: `qos_arb`

## Requirements
- R1: When no initiator is valid, `grant_o` is all zeros and `slv_valid_o` is low.
- R2: `grant_o` never has more than one bit set.
- R3: An unlocked grant goes to a valid initiator whose priority equals the maximum priority among all valid initiators.
- R4: While `slv_valid_o` is high and `slv_ready_i` is low, `grant_o` keeps its value in the next cycle. This holds even if a request with a higher priority arrives.
- R5: After a handshake completes, the next grant goes to the highest-priority request then present, even if lower-priority requests have been waiting longer.
- R6: Ties at the top priority are broken by a pointer. The pointer is 0 after reset and is set to (last handshaken index + 1) mod N_REQ. The tie goes to the first tied index at or cyclically after the pointer.
- R7: `slv_pay_o` and `slv_qos_o` carry the granted initiator's payload and priority. Bit i of `req_ready_o` is high only when bit i of `grant_o` is high and `slv_ready_i` is high.
- R8: Contending initiators are served one per handshake in descending priority order, for example 15, then 8, then 4.
- R9: A lone valid initiator with priority 0 is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | N_REQ | Request valid, one bit per initiator |
| req_qos_i | input | N_REQ*QOS_W | Priority values; initiator i occupies bits [i*QOS_W +: QOS_W] |
| req_pay_i | input | N_REQ*PAY_W | Address payloads; initiator i occupies bits [i*PAY_W +: PAY_W] |
| req_ready_o | output | N_REQ | Ready returned to each initiator |
| grant_o | output | N_REQ | One-hot grant, or all zeros |
| slv_valid_o | output | 1 | Request valid toward the target |
| slv_qos_o | output | QOS_W | Priority of the granted request |
| slv_pay_o | output | PAY_W | Payload of the granted request |
| slv_ready_i | input | 1 | Target ready |

## Verification
A corrupted lock register shows up at the ports in one of two ways within one cycle of a stalled handshake. The grant may move while the target still holds ready low. Alternatively, a late high-priority request may take the port before the pending handshake completes. A wrong round-robin pointer is invisible until a tie occurs at the top priority. It then shows as a wrong initiator index on the very handshake that resolves that tie. A faulty maximum search shows as a handshake order that differs from descending priority order. The scoreboard catches this at the first handshake that takes place while contention is present.

// File: rtl/qos_arb_pkg.sv
package qos_arb_pkg;
  timeunit 1ns; timeprecision 1ps;
  localparam int unsigned QOS_BITS = 4;
  typedef logic [QOS_BITS-1:0] qos_t;
endpackage

// File: rtl/qos_max.sv
module qos_max #(
  parameter int unsigned N  = 4,
  parameter int unsigned QW = 4
) (
  input  logic [N-1:0]    valid_i,
  input  logic [N*QW-1:0] qos_i,
  output logic [QW-1:0]   max_o
);
  timeunit 1ns; timeprecision 1ps;
  // invalid requesters never contribute
  always_comb begin
    max_o = '0;
    for (int i = 0; i < N; i++)
      if (valid_i[i] && qos_i[i*QW +: QW] > max_o) max_o = qos_i[i*QW +: QW];
  end
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = 2
) (
  input  logic [N-1:0]  cand_i,
  input  logic [IW-1:0] ptr_i,
  output logic [N-1:0]  pick_o,
  output logic [IW-1:0] idx_o
);
  timeunit 1ns; timeprecision 1ps;
  always_comb begin
    logic found;
    pick_o = '0;
    idx_o  = '0;
    found  = 1'b0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = int'(ptr_i) + k;
      if (j >= int'(N)) j = j - int'(N);
      if (!found && cand_i[j]) begin
        found     = 1'b1;
        pick_o[j] = 1'b1;
        idx_o     = IW'(j);
      end
    end
  end
endmodule

// File: rtl/onehot_mux.sv
module onehot_mux #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 32
) (
  input  logic [N-1:0]   sel_i,
  input  logic [N*W-1:0] data_i,
  output logic [W-1:0]   data_o
);
  timeunit 1ns; timeprecision 1ps;
  always_comb begin
    data_o = '0;
    for (int i = 0; i < N; i++)
      data_o |= data_i[i*W +: W] & {W{sel_i[i]}};
  end
endmodule

// File: rtl/qos_arb.sv
module qos_arb
  import qos_arb_pkg::*;
#(
  parameter int unsigned N_REQ = 4,
  parameter int unsigned QOS_W = QOS_BITS,
  parameter int unsigned PAY_W = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_REQ-1:0]       req_valid_i,
  input  logic [N_REQ*QOS_W-1:0] req_qos_i,
  input  logic [N_REQ*PAY_W-1:0] req_pay_i,
  output logic [N_REQ-1:0]       req_ready_o,
  output logic [N_REQ-1:0]       grant_o,
  output logic                   slv_valid_o,
  output logic [QOS_W-1:0]       slv_qos_o,
  output logic [PAY_W-1:0]       slv_pay_o,
  input  logic                   slv_ready_i
);
  timeunit 1ns; timeprecision 1ps;
  localparam int unsigned IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_REQ - 1);

  logic [QOS_W-1:0] max_qos;
  logic [N_REQ-1:0] cand, pick_c, gnt_q;
  logic [IDX_W-1:0] pick_idx, idx_q, ptr_q, gnt_idx;
  logic             lock_q, hs;

  qos_max #(.N(N_REQ), .QW(QOS_W)) u_max (
    .valid_i(req_valid_i), .qos_i(req_qos_i), .max_o(max_qos)
  );

  for (genvar g = 0; g < N_REQ; g++) begin : g_cand
    assign cand[g] = req_valid_i[g] && (req_qos_i[g*QOS_W +: QOS_W] == max_qos);
  end

  rr_pick #(.N(N_REQ), .IW(IDX_W)) u_pick (
    .cand_i(cand), .ptr_i(ptr_q), .pick_o(pick_c), .idx_o(pick_idx)
  );

  assign grant_o     = lock_q ? gnt_q : pick_c;
  assign gnt_idx     = lock_q ? idx_q : pick_idx;
  assign slv_valid_o = |(grant_o & req_valid_i);
  assign hs          = slv_valid_o & slv_ready_i;
  assign req_ready_o = grant_o & {N_REQ{slv_ready_i}};

  onehot_mux #(.N(N_REQ), .W(PAY_W)) u_pay (
    .sel_i(grant_o), .data_i(req_pay_i), .data_o(slv_pay_o)
  );
  onehot_mux #(.N(N_REQ), .W(QOS_W)) u_qos (
    .sel_i(grant_o), .data_i(req_qos_i), .data_o(slv_qos_o)
  );

  // lock a stalled grant; release and advance pointer on handshake
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      gnt_q  <= '0;
      idx_q  <= '0;
      ptr_q  <= '0;
    end else if (hs) begin
      lock_q <= 1'b0;
      ptr_q  <= (gnt_idx == LAST_IDX) ? '0 : gnt_idx + 1'b1;
    end else if (slv_valid_o && !lock_q) begin
      lock_q <= 1'b1;
      gnt_q  <= pick_c;
      idx_q  <= pick_idx;
    end
  end

  AST_IDLE_NO_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|req_valid_i) |-> (grant_o == '0) && !slv_valid_o);  // R1
  AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));  // R2
  AST_GRANT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slv_valid_o && !slv_ready_i |=> $stable(grant_o));  // R4
  AST_READY_ONLY_GRANTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o & ~grant_o) == '0);  // R7
  for (genvar a = 0; a < N_REQ; a++) begin : g_ast
    AST_GRANT_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grant_o[a] |-> req_valid_i[a]);  // R3
  end
endmodule

// File: tb/sim_qos_arb.sv
module sim_qos_arb;
  timeunit 1ns; timeprecision 1ps;
  localparam int N = 4;
  localparam int QW = 4;
  localparam int PW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] pend = '0;
  logic [QW-1:0] mq [N];
  logic [PW-1:0] mp [N];
  logic [N*QW-1:0] qos_flat;
  logic [N*PW-1:0] pay_flat;
  logic [N-1:0] req_ready, grant;
  logic slv_valid, slv_ready = 1'b0;
  logic [QW-1:0] slv_qos;
  logic [PW-1:0] slv_pay;
  int checks = 0, errors = 0, seq = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      qos_flat[i*QW +: QW] = mq[i];
      pay_flat[i*PW +: PW] = mp[i];
    end
  end

  qos_arb #(.N_REQ(N), .QOS_W(QW), .PAY_W(PW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(pend), .req_qos_i(qos_flat),
    .req_pay_i(pay_flat), .req_ready_o(req_ready), .grant_o(grant),
    .slv_valid_o(slv_valid), .slv_qos_o(slv_qos), .slv_pay_o(slv_pay),
    .slv_ready_i(slv_ready)
  );

  task automatic chk(string req, logic [PW-1:0] act, logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic issue(int idx, int q);
    seq++;
    pend[idx] = 1'b1;
    mq[idx]   = QW'(q);
    mp[idx]   = 32'hA500_0000 + PW'(seq * 16 + idx);
  endtask

  // monitor: pop expected winner at every handshake
  always @(posedge clk) begin
    if (rst_n && slv_valid && slv_ready) begin
      int act;
      act = -1;
      for (int i = 0; i < N; i++) if (grant[i]) act = i;
      if (exp_q.size() == 0) begin
        chk("R8 unexpected handshake", PW'(act), 32'hFFFF_FFFF);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk("R3/R6/R8 winner index", PW'(act), PW'(e));
        chk("R7 payload", slv_pay, mp[e]);
        chk("R7 qos", PW'(slv_qos), PW'(mq[e]));
      end
      for (int i = 0; i < N; i++) if (req_ready[i]) pend[i] <= 1'b0;
    end
  end

  task automatic drain(string req);
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (pend == '0 && exp_q.size() == 0) break;
    end
    chk(req, PW'(exp_q.size()) | PW'(pend), '0);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin mq[i] = '0; mp[i] = '0; end
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset grant", PW'(grant), '0);
    chk("R1 reset valid", PW'(slv_valid), '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: lone priority-0 request
    slv_ready = 1'b1;
    issue(2, 0); exp_q.push_back(2);
    #1 chk("R9 lone qos0 grant", PW'(grant), 32'h4);
    drain("R9 drain");

    // R8/R4: three contenders, stalled target
    slv_ready = 1'b0;
    issue(0, 15); issue(1, 8); issue(3, 4);
    exp_q.push_back(0); exp_q.push_back(1); exp_q.push_back(3);
    #1 chk("R3 max qos grant", PW'(grant), 32'h1);
    repeat (3) @(negedge clk);
    #1;
    chk("R4 grant held", PW'(grant), 32'h1);
    chk("R7 no ready while stalled", PW'(req_ready), '0);
    chk("R7 payload routed", slv_pay, mp[0]);
    slv_ready = 1'b1;
    drain("R8 descending drain");
    #1;
    chk("R1 idle grant", PW'(grant), '0);
    chk("R1 idle valid", PW'(slv_valid), '0);

    // R5: late high-priority request wins after lock releases
    slv_ready = 1'b0;
    issue(3, 2); issue(1, 3);
    @(negedge clk);
    #1 chk("R3 locked winner", PW'(grant), 32'h2);
    issue(0, 9);
    #1 chk("R4 held against higher qos", PW'(grant), 32'h2);
    @(negedge clk);
    exp_q.push_back(1); exp_q.push_back(0); exp_q.push_back(3);
    slv_ready = 1'b1;
    #1 chk("R7 ready to granted", PW'(req_ready), 32'h2);
    drain("R5 drain");

    // R6: ties resolved by pointer (pointer is 0 here)
    issue(0, 7); issue(1, 7); issue(2, 7); issue(3, 7);
    exp_q.push_back(0); exp_q.push_back(1); exp_q.push_back(2); exp_q.push_back(3);
    drain("R6 four-way tie");
    issue(1, 5); exp_q.push_back(1);
    drain("R6 move pointer");
    issue(0, 5); issue(3, 5);
    exp_q.push_back(3); exp_q.push_back(0);
    drain("R6 tie after pointer 2");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule